// File: doc/BRIEF.md
# I2C Master Start-Condition Controller

This block lives inside an I2C master and turns a host start request into a start condition on the open-drain SDA and SCL lines. On a free bus it pulls SDA low while SCL is high, keeps SDA low for a set number of clocks, then pulls SCL low and holds both lines. The byte engine then takes over the bus. When this master is paused in its wait state between bytes, the block ends the wait and produces a repeated start.

A two-stage synchronizer and a start/stop detector on the sampled lines keep a bus-busy flag. If another master owns the bus, the request is either queued and fired as soon as a stop frees the bus, or refused with a sticky failure flag. A mode bit selects which. The pending request is dropped on arbitration loss, on a release command, when the block is disabled, and once the start has been produced. Requests that collide with a stop request, that arrive while one is already pending, or that come at the wrong point of a transfer are ignored.

Top module: `i2c_start_ctrl`

## Requirements
- R1: On a request with the bus idle and the master not active, `sda_oe` goes high one clock after the request. `scl_oe` stays low for exactly HOLD clocks (default 5), then rises, and both enables stay high.
- R2: On a request while the bus is busy, the master is not active and `rsv_disable`=0, `rsv_pend` and `start_pend` go high and the lines are left alone. Once `bus_busy` falls, `sda_oe` rises on the next clock.
- R3: On a request while the bus is busy, the master is not active and `rsv_disable`=1, `start_fail` is set, `start_pend` stays 0 and no enable is asserted. An accepted request or disable clears `start_fail`.
- R4: On a request while the master is active and in its wait state, `wait_rel` and `scl_oe` go high with `sda_oe` low for HOLD clocks. Then `scl_oe` is released. SDA is pulled low once SCL has read high through the two-stage synchronizer for HOLD clocks (HOLD+2 clocks after release, counted on the line). After another HOLD clocks SCL is pulled low.
- R5: `start_pend` clears on `arb_lost`, on `release_cmd`, and on `enable`=0. Any queued start is discarded and is not fired after the bus is freed.
- R6: A start request in the same clock as `stop_req` is ignored.
- R7: A start request while `start_pend` is 1 is ignored. In particular it cannot set `start_fail`.
- R8: While the master is active and `mst_wait`=0 (mid-transfer, including the acknowledge clock), a start request is ignored.
- R9: While the master is active, waiting and receiving (`mst_rx`=1), a request is taken only if `ack_en`=0 and `rx_final`=1. Otherwise it is ignored.
- R10: Once both enables are asserted the start is taken: `start_pend` reads 0. A `byte_go` pulse releases both enables.
- R11: `bus_busy` rises after SDA falls while SCL is high, and falls after SDA rises while SCL is high. A repeated start leaves it high. `enable`=0 forces it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; 0 clears all state |
| rsv_disable | input | 1 | 1 = refuse starts on a busy bus, 0 = queue them |
| start_req | input | 1 | Start request strobe |
| stop_req | input | 1 | Stop request strobe (collision check only) |
| release_cmd | input | 1 | Exit-communication strobe; drops a pending start |
| arb_lost | input | 1 | Arbitration-loss pulse |
| mst_active | input | 1 | This device currently owns the bus as master |
| mst_wait | input | 1 | Master is in the wait period after the ninth clock |
| mst_rx | input | 1 | Current master transfer is a reception |
| ack_en | input | 1 | ACK generation enabled for reception |
| rx_final | input | 1 | Final byte of a reception has been received |
| byte_go | input | 1 | Byte engine takes over the lines after a start |
| sda_i | input | 1 | Sampled SDA line |
| scl_i | input | 1 | Sampled SCL line |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 pulls SCL low |
| wait_rel | output | 1 | Tells the byte engine to release its wait hold |
| start_pend | output | 1 | Start request pending (not yet taken) |
| rsv_pend | output | 1 | Start queued behind another master |
| start_fail | output | 1 | Sticky: start refused on a busy bus |
| bus_busy | output | 1 | Bus-busy flag from line monitor |

## Verification
Two things can fall in the same clock: the arrival of a host request and a change in the bus state. One case is a start strobe together with a stop strobe. The other is a queued start whose firing depends on the very clock in which the monitor drops `bus_busy`. The bench drives the two strobes on one edge and checks that no enable or pending flag moves. It also releases the other master's stop, polls for the first clock with `bus_busy` low, and requires `sda_oe` exactly one clock later. A second request during a reservation, with refusal mode selected, must leave `start_fail` clear.

// File: rtl/i2c_start_pkg.sv
// Package: shared state encoding for the start-condition controller.
package i2c_start_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,  // no request
        ST_RSV    = 3'd1,  // queued behind another master
        ST_RS_SDA = 3'd2,  // repeated start: SDA released, SCL held
        ST_RS_SCL = 3'd3,  // repeated start: SCL released, waiting high time
        ST_GEN    = 3'd4,  // SDA low, SCL high (start hold)
        ST_HELD   = 3'd5   // both low, waiting for byte engine
    } st_e;
endpackage

// File: rtl/i2c_line_mon.sv
// Line monitor: synchronizes SDA/SCL and tracks bus-busy from start/stop
// edges. Assumes raw lines are asynchronous; SYNC_STAGES >= 2.
module i2c_line_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic sda_i,
    input  logic scl_i,
    output logic sda_s,
    output logic scl_s,
    output logic busy
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] sda_ff;
    logic [TOP:0] scl_ff;
    logic         sda_prev;
    logic         scl_prev;
    logic         start_seen;
    logic         stop_seen;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            // shift both lines through the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sda_ff <= '1;
                    scl_ff <= '1;
                end else begin
                    sda_ff <= {sda_ff[TOP-1:0], sda_i};
                    scl_ff <= {scl_ff[TOP-1:0], scl_i};
                end
            end
        end else begin : g_single
            // single stage variant
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sda_ff <= '1;
                    scl_ff <= '1;
                end else begin
                    sda_ff <= sda_i;
                    scl_ff <= scl_i;
                end
            end
        end
    endgenerate

    assign sda_s = sda_ff[TOP];
    assign scl_s = scl_ff[TOP];

    // remember last synchronized values for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_prev <= 1'b1;
            scl_prev <= 1'b1;
        end else begin
            sda_prev <= sda_s;
            scl_prev <= scl_s;
        end
    end

    assign start_seen = sda_prev && !sda_s && scl_prev && scl_s;
    assign stop_seen  = !sda_prev && sda_s && scl_prev && scl_s;

    // busy flag: set by start, cleared by stop or disable
    always_ff @(posedge clk) begin
        if (!rst_n)          busy <= 1'b0;
        else if (!enable)    busy <= 1'b0;
        else if (start_seen) busy <= 1'b1;
        else if (stop_seen)  busy <= 1'b0;
    end

    // R11
    stop_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_seen && !start_seen) |=> !busy);
    // R11
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_seen && enable) |=> busy);
    // R11
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !busy);
endmodule

// File: rtl/i2c_hold_timer.sv
// Hold timer: counts clocks since the last clear; done after HOLD clocks
// in the current interval (done is high in the HOLD-th cycle). HOLD >= 1.
module i2c_hold_timer #(
    parameter int HOLD = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic done
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    logic [CW-1:0] cnt;

    assign done = (cnt == LAST);

    // count up from a clear, saturating at the last value
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (clr)   cnt <= '0;
        else if (!done) cnt <= cnt + 1'b1;
    end

    // R1
    timer_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/i2c_start_fsm.sv
// Start sequencer: decides whether a request is taken, queued, refused or
// ignored, and steps the SDA/SCL enables through start or repeated start.
// Assumes busy/scl_s come from the synchronized monitor.
module i2c_start_fsm
    import i2c_start_pkg::*;
#(
    parameter int HOLD = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic rsv_disable,
    input  logic start_req,
    input  logic stop_req,
    input  logic release_cmd,
    input  logic arb_lost,
    input  logic mst_active,
    input  logic mst_wait,
    input  logic mst_rx,
    input  logic ack_en,
    input  logic rx_final,
    input  logic byte_go,
    input  logic busy,
    input  logic scl_s,
    input  logic tmr_done,
    output logic tmr_clr,
    output logic sda_oe,
    output logic scl_oe,
    output logic wait_rel,
    output logic start_pend,
    output logic rsv_pend,
    output logic start_fail
);
    localparam int CW = $clog2(HOLD + 1);

    st_e  state;
    st_e  nxt;
    logic kill;
    logic req_ok;
    logic wait_ok;
    logic refuse;

    assign kill    = !enable || arb_lost || release_cmd;
    assign req_ok  = start_req && !stop_req;
    assign wait_ok = mst_wait && (!mst_rx || (!ack_en && rx_final));
    assign refuse  = !kill && (state == ST_IDLE) && req_ok && !mst_active
                     && busy && rsv_disable;

    // next-state selection
    always_comb begin
        nxt = state;
        if (kill) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_ok) begin
                        if (mst_active) begin
                            if (wait_ok) nxt = ST_RS_SDA;
                        end else if (busy) begin
                            if (!rsv_disable) nxt = ST_RSV;
                        end else begin
                            nxt = ST_GEN;
                        end
                    end
                end
                ST_RSV:    if (!busy)    nxt = ST_GEN;
                ST_RS_SDA: if (tmr_done) nxt = ST_RS_SCL;
                ST_RS_SCL: if (tmr_done) nxt = ST_GEN;
                ST_GEN:    if (tmr_done) nxt = ST_HELD;
                ST_HELD:   if (byte_go)  nxt = ST_IDLE;
                default:                 nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // failure flag: set on refusal, cleared on acceptance or disable
    always_ff @(posedge clk) begin
        if (!rst_n)                                   start_fail <= 1'b0;
        else if (!enable)                             start_fail <= 1'b0;
        else if (refuse)                              start_fail <= 1'b1;
        else if (state == ST_IDLE && nxt != ST_IDLE)  start_fail <= 1'b0;
    end

    assign tmr_clr    = (nxt != state) || (state == ST_RS_SCL && !scl_s);
    assign sda_oe     = (state == ST_GEN) || (state == ST_HELD);
    assign scl_oe     = (state == ST_RS_SDA) || (state == ST_HELD);
    assign wait_rel   = (state == ST_RS_SDA);
    assign rsv_pend   = (state == ST_RSV);
    assign start_pend = (state == ST_RSV) || (state == ST_RS_SDA) ||
                        (state == ST_RS_SCL) || (state == ST_GEN);

    // checker counter: length of the SDA-low, SCL-high phase
    logic [CW-1:0] gen_len;
    always_ff @(posedge clk) begin
        if (!rst_n)               gen_len <= '0;
        else if (state == ST_GEN) gen_len <= gen_len + 1'b1;
        else                      gen_len <= '0;
    end

    // R1
    start_hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(scl_oe) && sda_oe) |-> (gen_len == CW'(HOLD)));
    // R3
    fail_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_fail) |-> ($past(start_req) && $past(busy) && $past(rsv_disable)));
    // R5
    arb_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |=> !start_pend);
    // R6
    stop_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && stop_req && !start_pend && !sda_oe && !scl_oe && !kill)
        |=> (!start_pend && !sda_oe && !scl_oe));
    // R10
    taken_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe && scl_oe) |-> !start_pend);
endmodule

// File: rtl/i2c_start_ctrl.sv
// Top: I2C master start-condition controller. Joins the line monitor,
// hold timer and start sequencer. Outputs are open-drain enables (1 = low).
module i2c_start_ctrl #(
    parameter int HOLD        = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic rsv_disable,
    input  logic start_req,
    input  logic stop_req,
    input  logic release_cmd,
    input  logic arb_lost,
    input  logic mst_active,
    input  logic mst_wait,
    input  logic mst_rx,
    input  logic ack_en,
    input  logic rx_final,
    input  logic byte_go,
    input  logic sda_i,
    input  logic scl_i,
    output logic sda_oe,
    output logic scl_oe,
    output logic wait_rel,
    output logic start_pend,
    output logic rsv_pend,
    output logic start_fail,
    output logic bus_busy
);
    logic sda_s;
    logic scl_s;
    logic tmr_clr;
    logic tmr_done;

    i2c_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .sda_i   (sda_i),
        .scl_i   (scl_i),
        .sda_s   (sda_s),
        .scl_s   (scl_s),
        .busy    (bus_busy)
    );

    i2c_hold_timer #(.HOLD(HOLD)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .done  (tmr_done)
    );

    i2c_start_fsm #(.HOLD(HOLD)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .rsv_disable (rsv_disable),
        .start_req   (start_req),
        .stop_req    (stop_req),
        .release_cmd (release_cmd),
        .arb_lost    (arb_lost),
        .mst_active  (mst_active),
        .mst_wait    (mst_wait),
        .mst_rx      (mst_rx),
        .ack_en      (ack_en),
        .rx_final    (rx_final),
        .byte_go     (byte_go),
        .busy        (bus_busy),
        .scl_s       (scl_s),
        .tmr_done    (tmr_done),
        .tmr_clr     (tmr_clr),
        .sda_oe      (sda_oe),
        .scl_oe      (scl_oe),
        .wait_rel    (wait_rel),
        .start_pend  (start_pend),
        .rsv_pend    (rsv_pend),
        .start_fail  (start_fail)
    );

    // R2
    rsv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_pend |-> (!sda_oe && !scl_oe && start_pend));
endmodule

// File: tb/test_i2c_start_ctrl.sv
module test_i2c_start_ctrl;
    localparam int HOLD = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, rsv_disable = 1'b0, start_req = 1'b0, stop_req = 1'b0;
    logic release_cmd = 1'b0, arb_lost = 1'b0, mst_active = 1'b0, mst_wait = 1'b0;
    logic mst_rx = 1'b0, ack_en = 1'b0, rx_final = 1'b0, byte_go = 1'b0;
    logic ext_sda_low = 1'b0, ext_scl_low = 1'b0, eng_scl_low = 1'b0;
    logic sda_i, scl_i;
    logic sda_oe, scl_oe, wait_rel, start_pend, rsv_pend, start_fail, bus_busy;
    int   checks = 0;
    int   failures = 0;

    always #2 clk = ~clk;

    assign sda_i = !(sda_oe || ext_sda_low);
    assign scl_i = !(scl_oe || ext_scl_low || eng_scl_low);

    i2c_start_ctrl #(.HOLD(HOLD)) i_i2c_start_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .rsv_disable(rsv_disable),
        .start_req(start_req), .stop_req(stop_req), .release_cmd(release_cmd),
        .arb_lost(arb_lost), .mst_active(mst_active), .mst_wait(mst_wait),
        .mst_rx(mst_rx), .ack_en(ack_en), .rx_final(rx_final), .byte_go(byte_go),
        .sda_i(sda_i), .scl_i(scl_i), .sda_oe(sda_oe), .scl_oe(scl_oe),
        .wait_rel(wait_rel), .start_pend(start_pend), .rsv_pend(rsv_pend),
        .start_fail(start_fail), .bus_busy(bus_busy)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
    endtask

    task automatic other_start();
        @(negedge clk) ext_sda_low = 1'b1;
        repeat (4) @(negedge clk);
        ext_scl_low = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic stop_edge();
        @(negedge clk) begin ext_sda_low = 1'b1; ext_scl_low = 1'b1; end
        repeat (4) @(negedge clk);
        ext_scl_low = 1'b0;
        repeat (4) @(negedge clk);
        ext_sda_low = 1'b0;
    endtask

    task automatic bus_stop();
        stop_edge();
        repeat (6) @(negedge clk);
    endtask

    task automatic wait_held();
        for (int i = 0; i < 60 && !(sda_oe && scl_oe); i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R11", "busy after reset", bus_busy, 0);
        chk("R1", "enables after reset", {sda_oe, scl_oe}, 0);
        chk("R5", "pend/fail after reset", {start_pend, rsv_pend, start_fail}, 0);
    endtask

    // R1 + R10 + R11
    task automatic t_idle_start();
        int n = 0;
        pulse_start();
        chk("R1", "sda_oe one clock after request", sda_oe, 1);
        chk("R1", "scl_oe still low", scl_oe, 0);
        while (sda_oe && !scl_oe && n < 50) begin n++; @(negedge clk); end
        chk("R1", "SDA-only clocks", n, HOLD);
        chk("R1", "both enables held", {sda_oe, scl_oe}, 3);
        chk("R10", "start_pend after start taken", start_pend, 0);
        chk("R11", "busy after own start", bus_busy, 1);
        @(negedge clk) byte_go = 1'b1;
        @(negedge clk) byte_go = 1'b0;
        chk("R10", "byte_go releases enables", {sda_oe, scl_oe}, 0);
        bus_stop();
        chk("R11", "busy cleared by stop", bus_busy, 0);
    endtask

    // R11
    task automatic t_monitor();
        other_start();
        chk("R11", "busy after foreign start", bus_busy, 1);
        bus_stop();
        chk("R11", "busy after foreign stop", bus_busy, 0);
    endtask

    // R3
    task automatic t_refuse();
        other_start();
        rsv_disable = 1'b1;
        pulse_start();
        chk("R3", "start_fail on refusal", start_fail, 1);
        chk("R3", "no pend on refusal", start_pend, 0);
        repeat (3) @(negedge clk);
        chk("R3", "no enables on refusal", {sda_oe, scl_oe}, 0);
        rsv_disable = 1'b0;
    endtask

    // R2 + R7 (bus still held by t_refuse)
    task automatic t_reserve();
        pulse_start();
        chk("R2", "rsv_pend queued", rsv_pend, 1);
        chk("R3", "accepted request clears fail", start_fail, 0);
        @(negedge clk) begin start_req = 1'b1; rsv_disable = 1'b1; end
        @(negedge clk) begin start_req = 1'b0; rsv_disable = 1'b0; end
        chk("R7", "second request leaves fail clear", start_fail, 0);
        chk("R7", "reservation still queued", rsv_pend, 1);
        chk("R2", "lines untouched while queued", {sda_oe, scl_oe}, 0);
        stop_edge();
        for (int i = 0; i < 20 && bus_busy; i++) @(negedge clk);
        chk("R2", "sda_oe at first free clock", sda_oe, 0);
        @(negedge clk);
        chk("R2", "sda_oe one clock after free", sda_oe, 1);
        wait_held();
        @(negedge clk) byte_go = 1'b1;
        @(negedge clk) byte_go = 1'b0;
        bus_stop();
    endtask

    // R5: arb loss, disable, release
    task automatic t_drops();
        other_start();
        pulse_start();
        @(negedge clk) arb_lost = 1'b1;
        @(negedge clk) arb_lost = 1'b0;
        chk("R5", "arb_lost drops pend", {start_pend, rsv_pend}, 0);
        bus_stop();
        chk("R5", "no start after arb loss", sda_oe, 0);
        other_start();
        pulse_start();
        @(negedge clk) enable = 1'b0;
        @(negedge clk);
        chk("R5", "disable drops pend", start_pend, 0);
        chk("R11", "disable clears busy", bus_busy, 0);
        bus_stop();
        enable = 1'b1;
        @(negedge clk);
        chk("R5", "no start after disable", sda_oe, 0);
        pulse_start();
        @(negedge clk) release_cmd = 1'b1;
        @(negedge clk) release_cmd = 1'b0;
        chk("R5", "release drops pend", {start_pend, sda_oe}, 0);
        repeat (8) @(negedge clk);
    endtask

    // R6
    task automatic t_collide();
        @(negedge clk) begin start_req = 1'b1; stop_req = 1'b1; end
        @(negedge clk) begin start_req = 1'b0; stop_req = 1'b0; end
        chk("R6", "start with stop ignored", {start_pend, sda_oe, scl_oe}, 0);
    endtask

    // R8 + R9 + R4 + R5
    task automatic t_master_wait();
        int n = 0;
        pulse_start();
        wait_held();
        @(negedge clk) begin byte_go = 1'b1; eng_scl_low = 1'b1; ext_sda_low = 1'b1; end
        @(negedge clk) begin byte_go = 1'b0; mst_active = 1'b1; end
        pulse_start();
        chk("R8", "request mid-transfer ignored", {start_pend, wait_rel}, 0);
        mst_wait = 1'b1; mst_rx = 1'b1; ack_en = 1'b1; rx_final = 1'b1;
        pulse_start();
        chk("R9", "rx with ACK on ignored", start_pend, 0);
        ack_en = 1'b0; rx_final = 1'b0;
        pulse_start();
        chk("R9", "rx before final byte ignored", start_pend, 0);
        rx_final = 1'b1;
        pulse_start();
        chk("R9", "rx final no-ACK accepted", {wait_rel, start_pend}, 3);
        @(negedge clk) release_cmd = 1'b1;
        @(negedge clk) release_cmd = 1'b0;
        chk("R5", "release drops repeated start", {start_pend, scl_oe}, 0);
        mst_rx = 1'b0; ack_en = 1'b1;
        pulse_start();
        chk("R4", "wait_rel/scl_oe/sda_oe", {wait_rel, scl_oe, sda_oe}, 6);
        @(negedge clk) begin eng_scl_low = 1'b0; ext_sda_low = 1'b0; end
        for (int i = 0; i < 40 && scl_oe; i++) @(negedge clk);
        chk("R4", "SDA high when SCL released", sda_i, 1);
        while (!sda_oe && scl_i && n < 50) begin n++; @(negedge clk); end
        chk("R4", "SCL high clocks before SDA fall", n, HOLD + 2);
        wait_held();
        chk("R4", "repeated start held", {sda_oe, scl_oe, start_pend}, 6);
        chk("R11", "busy kept over repeated start", bus_busy, 1);
        @(negedge clk) begin byte_go = 1'b1; mst_active = 1'b0; mst_wait = 1'b0; end
        @(negedge clk) byte_go = 1'b0;
        bus_stop();
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        enable = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_start();
        t_monitor();
        t_refuse();
        t_reserve();
        t_drops();
        t_collide();
        t_master_wait();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                failures++;
                $display("FAIL watchdog: actual=1 expected=0");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule